// File: doc/BRIEF.md
# Reset-Vector Address Unit

This unit is the address front end of a small processor with an 8-bit data bus and a 16-bit address bus. When reset is released it does not begin fetching from a fixed constant. Instead it reads a two-byte start pointer from the two highest locations of the address space, assembles that pointer in a pair of byte-wide staging registers, and copies it into the program counter. Only after that does it raise a completion flag and hand the bus over to normal operation.

After boot, the unit keeps the same datapath. The two staging bytes can be filled from the data bus one at a time, and their joined 16-bit value can be copied into the program counter or into a separate address register. The program counter can also step forward by one. A select line chooses whether the program counter or the address register drives the address bus. Memory is assumed to return read data one clock after the address is presented.

Top module: `rvec_addr_unit`

## Requirements
- R1: While reset is asserted, the program counter, the address register and the completion flag are all zero, and the address bus shows zero. Reset acts asynchronously.
- R2: In the first clock cycle after reset is released, the address bus shows 0xFFFE. In the second cycle it shows 0xFFFF. In the three cycles after that it shows the program counter.
- R3: The byte read from 0xFFFE becomes the low byte of the pointer and the byte read from 0xFFFF becomes the high byte. In the cycle where the completion flag first goes high, the program counter equals that pointer.
- R4: The completion flag goes high in the fifth cycle after reset release and stays high until the next reset.
- R5: Until the completion flag is high, the staging-load, program-counter-load, increment and address-register-load inputs have no effect.
- R6: After boot, an increment request with no load request raises the program counter by one at the next clock edge, and 0xFFFF steps to 0x0000.
- R7: After boot, the low-staging and high-staging load inputs each capture the data-bus byte present at the clock edge. A program-counter load copies {high staging, low staging} into the counter and takes priority over a simultaneous increment.
- R8: After boot, an address-register load copies {high staging, low staging} into the address register at the next clock edge.
- R9: After boot, the address bus shows the program counter when the select input is 0 and the address register when it is 1.
- R10: Asserting reset in the middle of operation clears the unit and restarts the whole boot read sequence, so a new pointer stored at the top of memory is picked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 8 | Read data from memory, one cycle after the address |
| stg_lo_ld | input | 1 | Load the low staging byte from mem_rdata |
| stg_hi_ld | input | 1 | Load the high staging byte from mem_rdata |
| pc_ld_stg | input | 1 | Copy the staged 16-bit value into the program counter |
| pc_inc | input | 1 | Increment the program counter |
| ar_ld_stg | input | 1 | Copy the staged 16-bit value into the address register |
| addr_sel | input | 1 | Bus source: 0 program counter, 1 address register |
| mem_addr | output | 16 | Address bus |
| pc_q | output | 16 | Program counter value |
| ar_q | output | 16 | Address register value |
| boot_done | output | 1 | Boot pointer loaded; normal operation active |

## Verification
The bench uses the default widths, a 16-bit address and an 8-bit data byte. With these widths the boot pointer sits at 0xFFFE and 0xFFFF, and the wrap from 0xFFFF to 0x0000 happens at the real edge of the space. A second boot loads the pointer 0xFFFE, so two increments after boot reach that wrap directly. A behavioural model tracks the boot step count, both staging bytes and both address registers. On every clock it predicts the bus address, the flag and the register values, with all control inputs held high during boot and then driven with random values.

// File: rtl/rvu_pkg.sv
package rvu_pkg;
   typedef enum logic [2:0] {
      BS_IDLE,
      BS_VLO,
      BS_VHI,
      BS_CAPH,
      BS_LDPC,
      BS_RUN
   } boot_st_e;
endpackage

// File: rtl/rvu_reg.sv
module rvu_reg #(
   parameter int W       = 8,
   parameter bit HAS_INC = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         inc,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("rvu_reg: W must be positive");
   end

   generate
      if (HAS_INC) begin : g_cnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (ld)  q <= d;
            else if (inc) q <= q + W'(1);
         end
      end else begin : g_plain
         logic unused_inc;
         assign unused_inc = inc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (ld) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/rvu_boot_seq.sv
module rvu_boot_seq
   import rvu_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              done,
   output logic              vec_drive,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              cap_lo,
   output logic              cap_hi,
   output logic              pc_boot_ld
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   boot_st_e st, st_nx;

   always_comb begin
      case (st)
         BS_IDLE: st_nx = BS_VLO;
         BS_VLO:  st_nx = BS_VHI;
         BS_VHI:  st_nx = BS_CAPH;
         BS_CAPH: st_nx = BS_LDPC;
         BS_LDPC: st_nx = BS_RUN;
         default: st_nx = BS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= BS_IDLE;
      else        st <= st_nx;
   end

   assign vec_drive  = (st == BS_VLO) || (st == BS_VHI);
   assign vec_addr   = (st == BS_VLO) ? TOP_ADDR - ADDR_W'(1) : TOP_ADDR;
   assign cap_lo     = (st == BS_VHI);
   assign cap_hi     = (st == BS_CAPH);
   assign pc_boot_ld = (st == BS_LDPC);
   assign done       = (st == BS_RUN);
endmodule

// File: rtl/rvu_addr_mux.sv
module rvu_addr_mux #(
   parameter int ADDR_W = 16
) (
   input  logic              boot_drive,
   input  logic [ADDR_W-1:0] boot_addr,
   input  logic              sel_ar,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] ar,
   output logic [ADDR_W-1:0] bus
);
   always_comb begin
      if (boot_drive)  bus = boot_addr;
      else if (sel_ar) bus = ar;
      else             bus = pc;
   end
endmodule

// File: rtl/rvec_addr_unit.sv
module rvec_addr_unit #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              stg_lo_ld,
   input  logic              stg_hi_ld,
   input  logic              pc_ld_stg,
   input  logic              pc_inc,
   input  logic              ar_ld_stg,
   input  logic              addr_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] ar_q,
   output logic              boot_done
);
   localparam int NBYTES = ADDR_W / DATA_W;

   if (ADDR_W != 2 * DATA_W) begin : g_bad_geom
      $error("rvec_addr_unit: ADDR_W must be twice DATA_W");
   end

   logic              vec_drive, cap_lo, cap_hi, pc_boot_ld;
   logic [ADDR_W-1:0] vec_addr;
   logic [NBYTES-1:0] byte_ld;
   logic [ADDR_W-1:0] staged;

   rvu_boot_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (boot_done),
      .vec_drive  (vec_drive),
      .vec_addr   (vec_addr),
      .cap_lo     (cap_lo),
      .cap_hi     (cap_hi),
      .pc_boot_ld (pc_boot_ld)
   );

   assign byte_ld[0] = cap_lo | (boot_done & stg_lo_ld);
   assign byte_ld[1] = cap_hi | (boot_done & stg_hi_ld);

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_stg
         rvu_reg #(.W(DATA_W), .HAS_INC(1'b0)) u_stg (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (byte_ld[b]),
            .inc   (1'b0),
            .d     (mem_rdata),
            .q     (staged[b*DATA_W +: DATA_W])
         );
      end
   endgenerate

   rvu_reg #(.W(ADDR_W), .HAS_INC(1'b1)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (pc_boot_ld | (boot_done & pc_ld_stg)),
      .inc   (boot_done & pc_inc),
      .d     (staged),
      .q     (pc_q)
   );

   rvu_reg #(.W(ADDR_W), .HAS_INC(1'b0)) u_ar (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (boot_done & ar_ld_stg),
      .inc   (1'b0),
      .d     (staged),
      .q     (ar_q)
   );

   rvu_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
      .boot_drive (vec_drive),
      .boot_addr  (vec_addr),
      .sel_ar     (addr_sel),
      .pc         (pc_q),
      .ar         (ar_q),
      .bus        (mem_addr)
   );
endmodule

// File: rtl/rvu_chk.sv
module rvu_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              pc_ld_stg,
   input logic              pc_inc,
   input logic              addr_sel,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] pc_q,
   input logic [ADDR_W-1:0] ar_q,
   input logic              boot_done
);
   localparam logic [ADDR_W-1:0] VEC_HI_A = '1;
   localparam logic [ADDR_W-1:0] VEC_LO_A = VEC_HI_A - ADDR_W'(1);

   a_r2_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot_done && mem_addr == VEC_LO_A) |=> (mem_addr == VEC_HI_A));

   a_r3_pc_holds_vector: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_done) |-> (pc_q == {$past(mem_rdata, 2), $past(mem_rdata, 3)}));

   a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);

   a_r5_ar_frozen_boot: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_done |=> $stable(ar_q));

   a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done && pc_inc && !pc_ld_stg) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

   a_r9_bus_source: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |-> (mem_addr == (addr_sel ? ar_q : pc_q)));
endmodule

bind rvec_addr_unit rvu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rdata (mem_rdata),
   .pc_ld_stg (pc_ld_stg),
   .pc_inc    (pc_inc),
   .addr_sel  (addr_sel),
   .mem_addr  (mem_addr),
   .pc_q      (pc_q),
   .ar_q      (ar_q),
   .boot_done (boot_done)
);

// File: tb/tb_rvec_addr_unit.sv
`timescale 1ns/1ps
module tb_rvec_addr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mem_rdata = 8'h00;
   logic        stg_lo_ld = 0, stg_hi_ld = 0, pc_ld_stg = 0;
   logic        pc_inc = 0, ar_ld_stg = 0, addr_sel = 0;
   logic [15:0] mem_addr, pc_q, ar_q;
   logic        boot_done;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] vec = 16'h3C5A;

   always #2 clk = ~clk;

   rvec_addr_unit dut (
      .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
      .stg_lo_ld(stg_lo_ld), .stg_hi_ld(stg_hi_ld), .pc_ld_stg(pc_ld_stg),
      .pc_inc(pc_inc), .ar_ld_stg(ar_ld_stg), .addr_sel(addr_sel),
      .mem_addr(mem_addr), .pc_q(pc_q), .ar_q(ar_q), .boot_done(boot_done)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      if (a == 16'hFFFE)      return vec[7:0];
      else if (a == 16'hFFFF) return vec[15:8];
      else                    return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   always @(posedge clk) mem_rdata <= memf(mem_addr);

   // behavioural reference
   int          mstep = 0;
   logic [15:0] mpc = 0, mar = 0;
   logic [7:0]  mlo = 0, mhi = 0, mrd = 0;
   logic        prev_done = 0;

   function automatic logic [15:0] exp_bus();
      if (mstep == 1)      return 16'hFFFE;
      else if (mstep == 2) return 16'hFFFF;
      else if (mstep == 5) return addr_sel ? mar : mpc;
      else                 return mpc;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mstep = 0; mpc = 0; mar = 0; mlo = 0; mhi = 0;
      end else begin
         logic [15:0] st_old;
         logic [7:0]  rd_old;
         st_old = {mhi, mlo};
         rd_old = mrd;
         mrd = memf(exp_bus());
         if (mstep == 2) mlo = rd_old;
         else if (mstep == 3) mhi = rd_old;
         else if (mstep == 4) mpc = st_old;
         else if (mstep == 5) begin
            if (stg_lo_ld) mlo = rd_old;
            if (stg_hi_ld) mhi = rd_old;
            if (pc_ld_stg)   mpc = st_old;
            else if (pc_inc) mpc = mpc + 16'd1;
            if (ar_ld_stg) mar = st_old;
         end
         if (mstep < 5) mstep = mstep + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
      if (mstep < 5) begin
         chk("R2 bus during boot", mem_addr, exp_bus());
         chk("R5 pc during boot", pc_q, mpc);
         chk("R5 ar during boot", ar_q, mar);
         chk("R4 flag low during boot", boot_done, 1'b0);
      end else begin
         chk("R9 bus source", mem_addr, exp_bus());
         chk("R7 pc value", pc_q, mpc);
         chk("R8 ar value", ar_q, mar);
         chk("R4 flag high", boot_done, 1'b1);
         if (!prev_done) chk("R3 pc equals vector", pc_q, vec);
      end
      prev_done = (mstep == 5);
   endtask

   task automatic drive_all(input logic v);
      stg_lo_ld = v; stg_hi_ld = v; pc_ld_stg = v;
      pc_inc = v; ar_ld_stg = v; addr_sel = v;
   endtask

   task automatic drive_rand();
      logic [5:0] r;
      r = 6'($urandom);
      stg_lo_ld = r[0]; stg_hi_ld = r[1]; pc_ld_stg = r[2] & r[3];
      pc_inc = r[3]; ar_ld_stg = r[4] & r[0]; addr_sel = r[5];
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset pc", pc_q, 16'h0);
      chk("R1 reset ar", ar_q, 16'h0);
      chk("R1 reset flag", boot_done, 1'b0);
      chk("R1 reset bus", mem_addr, 16'h0);
      // R5: every request held high throughout boot
      drive_all(1'b1);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) cyc();
      for (int i = 0; i < 60; i++) begin drive_rand(); cyc(); end

      // R10: reset mid-run, new pointer at top of memory
      drive_all(1'b0);
      rst_n = 1'b0;
      vec = 16'hFFFE;
      #1;
      chk("R10 async clear pc", pc_q, 16'h0);
      chk("R10 async clear flag", boot_done, 1'b0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      pc_inc = 1'b1;
      for (int i = 0; i < 5; i++) cyc();
      chk("R10 reboot pc", pc_q, 16'hFFFE);
      cyc();
      chk("R6 pc step", pc_q, 16'hFFFF);
      cyc();
      chk("R6 wrap to zero", pc_q, 16'h0000);
      pc_inc = 1'b0;
      for (int i = 0; i < 80; i++) begin drive_rand(); cyc(); end
      summary();
      $finish;
   end
endmodule